// File: doc/BRIEF.md
# Triplicated Shift Chain with Mismatch Flag

This block is a long serial shift register in which every bit position is stored three times. Each position keeps three flip-flop copies of the same bit. All copies in the chain run on one shared clock. A small multiplexer-based voter forms the position's output as the majority of its copies. A second multiplexer forms a mismatch signal that is high whenever the copies differ. The voted output of each position feeds all three copies of the next position. A copy that has been corrupted is therefore rewritten with the correct value on the next clock edge.

The mismatch signals of all positions are ORed into one chain-wide error output. This output sits beside the voted serial data output. A sticky copy of the error holds any error seen until software-independent logic pulses a clear input. A test port can flip one chosen copy in one chosen position on a given edge. This exercises the voter and the detector without any physical upset.

Top module: `tmr_shift_chain`

## Requirements
- R1: A bit presented on `ser_in` appears on `ser_out` after exactly `NUM_STAGES` (default 100) rising clock edges, and the serial stream is passed on in order.
- R2: `ser_out` is the majority of the three copies of the last position. A single flipped copy in any position, including the last, never changes `ser_out` or the data passed downstream.
- R3: When an edge flips one copy, `mism_any` is high in the following cycle. It returns low after the next edge that has no flip, because every copy reloads the voted value of the previous position.
- R4: `flip_copy` selects the copy to flip, with the codes 0 = first copy, 1 = second copy, 2 = third copy and 3 = none. A `flip_pos` value of `NUM_STAGES` or more selects no position. Both of these no-target cases leave `mism_any` low and the data unchanged.
- R5: A flip in any single position raises the one shared `mism_any` output. This holds for the first, a middle and the last position.
- R6: `mism_hold` goes high on the edge after a cycle in which `mism_any` is high. It stays high while `mism_clr` is low.
- R7: Pulsing `mism_clr` in a cycle where `mism_any` is low clears `mism_hold` at that edge. If `mism_any` is high in the same cycle, the set wins and `mism_hold` stays high.
- R8: `rst_n` is synchronous and active low. It clears every copy, and with them `ser_out` and `mism_any`, and it clears `mism_hold`. A flip request during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for every copy in every position |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into the first position |
| flip_en | input | 1 | Test request: flip one copy on this edge |
| flip_pos | input | 7 | Index of the position to disturb (0 = first) |
| flip_copy | input | 2 | Copy to flip: 0, 1, 2, or 3 for none |
| mism_clr | input | 1 | Clears the sticky error flag |
| ser_out | output | 1 | Voted output of the last position |
| mism_any | output | 1 | OR of all per-position mismatch signals |
| mism_hold | output | 1 | Sticky version of `mism_any` |

## Verification
The bench flips each copy code in the first, a middle and the last position. In each case it checks that the voted stream matches a plain reference queue and that the shared flag rises for exactly one cycle. A voter wired to a single copy would corrupt the stream on a last-position flip. A stage that reloaded its own copies instead of the upstream vote would leave the flag stuck high. It sends the no-target codes and out-of-range positions, which a loose decoder would turn into spurious flags. It also measures the exact latency of a lone one travelling through a zeroed chain. The sticky flag is checked for clear against set at the same edge, and injection is attempted under reset.

// File: rtl/tmr_pkg.sv
// Shared types for the triplicated shift chain.
// Assumes three copies per position; the copy code 3 means "no copy".
package tmr_pkg;

    typedef enum logic [1:0] {
        COPY_FIRST  = 2'd0,
        COPY_SECOND = 2'd1,
        COPY_THIRD  = 2'd2,
        COPY_NONE   = 2'd3
    } copy_sel_e;

    // Turn a copy code into a one-hot flip mask (bit 0 = first copy).
    function automatic logic [2:0] copy_mask(input copy_sel_e sel);
        logic [2:0] m;
        case (sel)
            COPY_FIRST:  m = 3'b001;
            COPY_SECOND: m = 3'b010;
            COPY_THIRD:  m = 3'b100;
            default:     m = 3'b000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr_vote_mux.sv
// Majority voter and mismatch detector built as two 4-way selectors
// steered by copies a and b. Purely combinational; assumes 1-bit copies.
module tmr_vote_mux (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic vote_o,
    output logic mism_o
);

    // Voter selector: 00 -> 0, 01/10 -> c, 11 -> 1.
    always_comb begin
        case ({a_i, b_i})
            2'b00:   vote_o = 1'b0;
            2'b01:   vote_o = c_i;
            2'b10:   vote_o = c_i;
            default: vote_o = 1'b1;
        endcase
    end

    // Mismatch selector: 00 -> c, 01/10 -> 1, 11 -> not c.
    always_comb begin
        case ({a_i, b_i})
            2'b00:   mism_o = c_i;
            2'b01:   mism_o = 1'b1;
            2'b10:   mism_o = 1'b1;
            default: mism_o = ~c_i;
        endcase
    end

endmodule

// File: rtl/tmr_stage.sv
// One chain position: three copies loading the same upstream vote,
// each optionally inverted by a test flip mask, then voted.
// Assumes flip_i is at most one-hot.
module tmr_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       d_i,
    input  logic [2:0] flip_i,
    output logic       q_o,
    output logic       mism_o
);

    logic [2:0] copy_q;

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_copy
            // Load the upstream vote, inverted when this copy is flipped.
            always_ff @(posedge clk) begin
                if (!rst_n) copy_q[gi] <= 1'b0;
                else        copy_q[gi] <= d_i ^ flip_i[gi];
            end
        end
    endgenerate

    tmr_vote_mux u_vote (
        .a_i    (copy_q[0]),
        .b_i    (copy_q[1]),
        .c_i    (copy_q[2]),
        .vote_o (q_o),
        .mism_o (mism_o)
    );

    // A flip request drives at most one copy.
    assert_flip_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_i));

    // A single flip never reaches the voted output.
    assert_vote_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q_o == $past(d_i)));

    // A flip shows as a mismatch in the next cycle.
    assert_flag_on_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i != 3'b000) |=> mism_o);

    // Without a flip the copies agree after the edge.
    assert_heal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i == 3'b000) |=> !mism_o);

endmodule

// File: rtl/tmr_err_collect.sv
// ORs the per-position mismatch signals into one flag and keeps a
// sticky copy. Set has priority over clear at the same edge.
module tmr_err_collect #(
    parameter int NUM_STAGES = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] mism_i,
    input  logic                  clr_i,
    output logic                  err_o,
    output logic                  sticky_o
);

    // Chain-wide mismatch flag.
    always_comb err_o = |mism_i;

    // Sticky capture: a live error sets, clear drops it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_o <= 1'b0;
        else        sticky_o <= err_o | (sticky_o & ~clr_i);
    end

    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> sticky_o);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !clr_i) |=> sticky_o);

    assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !err_o) |=> !sticky_o);

endmodule

// File: rtl/tmr_shift_chain.sv
// Top level: NUM_STAGES triplicated positions in series on one clock,
// a test flip decoder per position, and the chain-wide error collector.
// Assumes flip_pos values of NUM_STAGES or more select nothing.
module tmr_shift_chain #(
    parameter int NUM_STAGES = 100,
    localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_pos,
    input  logic [1:0]       flip_copy,
    input  logic             mism_clr,
    output logic             ser_out,
    output logic             mism_any,
    output logic             mism_hold
);

    import tmr_pkg::*;

    logic [NUM_STAGES:0]   link;
    logic [NUM_STAGES-1:0] mism;
    logic [2:0]            req_mask;

    // Copy mask requested by the test port, shared by all positions.
    always_comb req_mask = flip_en ? copy_mask(copy_sel_e'(flip_copy)) : 3'b000;

    assign link[0] = ser_in;

    genvar k;
    generate
        for (k = 0; k < NUM_STAGES; k++) begin : g_pos
            logic [2:0] pos_mask;

            // Route the flip mask only to the addressed position.
            always_comb pos_mask = (flip_pos == IDX_W'(k)) ? req_mask : 3'b000;

            tmr_stage u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (link[k]),
                .flip_i (pos_mask),
                .q_o    (link[k+1]),
                .mism_o (mism[k])
            );
        end
    endgenerate

    assign ser_out = link[NUM_STAGES];

    tmr_err_collect #(.NUM_STAGES(NUM_STAGES)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .mism_i   (mism),
        .clr_i    (mism_clr),
        .err_o    (mism_any),
        .sticky_o (mism_hold)
    );

    // A reset edge leaves data, flag and sticky flag all low.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !mism_any && !mism_hold));

    // An ignored copy code never raises the flag.
    assert_none_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flip_en || flip_copy == 2'd3) |=> !mism_any);

endmodule

// File: tb/tb_tmr_shift_chain.sv
module tb_tmr_shift_chain;

    localparam int NS = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       flip_en = 1'b0;
    logic [6:0] flip_pos = '0;
    logic [1:0] flip_copy = 2'd3;
    logic       mism_clr = 1'b0;
    logic       ser_out, mism_any, mism_hold;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [NS-1:0] m_sh = '0;
    logic          m_err = 1'b0;
    logic          m_stk = 1'b0;

    always #5 clk = ~clk;

    tmr_shift_chain #(.NUM_STAGES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .flip_en(flip_en),
        .flip_pos(flip_pos), .flip_copy(flip_copy), .mism_clr(mism_clr),
        .ser_out(ser_out), .mism_any(mism_any), .mism_hold(mism_hold)
    );

    // Fields: [11] data, [10] flip enable, [9:3] position, [2:1] copy, [0] flag expected
    localparam logic [11:0] VEC [0:15] = '{
        {1'b1, 1'b1, 7'd0,   2'd0, 1'b1},
        {1'b0, 1'b0, 7'd0,   2'd0, 1'b0},
        {1'b1, 1'b1, 7'd50,  2'd1, 1'b1},
        {1'b1, 1'b1, 7'd99,  2'd2, 1'b1},
        {1'b0, 1'b1, 7'd99,  2'd0, 1'b1},
        {1'b1, 1'b0, 7'd0,   2'd3, 1'b0},
        {1'b0, 1'b1, 7'd10,  2'd3, 1'b0},
        {1'b1, 1'b1, 7'd120, 2'd0, 1'b0},
        {1'b1, 1'b1, 7'd127, 2'd2, 1'b0},
        {1'b0, 1'b1, 7'd1,   2'd1, 1'b1},
        {1'b0, 1'b1, 7'd98,  2'd2, 1'b1},
        {1'b1, 1'b0, 7'd0,   2'd0, 1'b0},
        {1'b1, 1'b1, 7'd33,  2'd0, 1'b1},
        {1'b0, 1'b1, 7'd33,  2'd1, 1'b1},
        {1'b1, 1'b1, 7'd33,  2'd2, 1'b1},
        {1'b0, 1'b0, 7'd0,   2'd0, 1'b0}
    };

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock step: drive, update the model, sample at the falling edge.
    task automatic step(input logic d, input logic en, input int pos,
                        input logic [1:0] cp, input logic clr, input string tag);
        logic nstk;
        ser_in = d; flip_en = en; flip_pos = 7'(pos); flip_copy = cp; mism_clr = clr;
        nstk  = rst_n ? (m_err | (m_stk & ~clr)) : 1'b0;
        m_err = rst_n && en && (pos < NS) && (cp != 2'd3);
        m_sh  = rst_n ? {m_sh[NS-2:0], d} : '0;
        m_stk = nstk;
        @(posedge clk);
        @(negedge clk);
        check(tag, "ser_out", ser_out, m_sh[NS-1]);
        check(tag, "mism_any", mism_any, m_err);
        check(tag, "mism_hold", mism_hold, m_stk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        // R8: reset with a pending flip and input data
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 99, 2'd0, 1'b0, "R8");
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5, model also covers R1 and R6
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][11], VEC[i][10], int'(VEC[i][9:3]), VEC[i][2:1], 1'b0, "R3");
            check("R5", "mism_any table", mism_any, VEC[i][0]);
        end
        check("R6", "mism_hold after table", mism_hold, 1'b1);

        // R7: clear with no live error drops the sticky flag
        step(1'b0, 1'b0, 0, 2'd3, 1'b1, "R7");
        check("R7", "mism_hold cleared", mism_hold, 1'b0);

        // R7: set beats clear when the error is live at the same edge
        step(1'b1, 1'b1, 70, 2'd1, 1'b0, "R7");
        step(1'b1, 1'b0, 0, 2'd3, 1'b1, "R7");
        check("R7", "mism_hold set priority", mism_hold, 1'b1);
        step(1'b0, 1'b0, 0, 2'd3, 1'b1, "R7");
        check("R7", "mism_hold clear after", mism_hold, 1'b0);

        // R1 / R2: stream a pattern while flipping copies in the last position
        for (int i = 0; i < 130; i++)
            step(((i * 7) % 5) < 2, (i % 3) == 0, 99, 2'(i % 4), 1'b0, "R2");

        // R1: exact latency of a lone one through a zeroed chain
        for (int i = 0; i < NS; i++) step(1'b0, 1'b0, 0, 2'd3, 1'b0, "R1");
        begin
            int lat;
            lat = 0;
            step(1'b1, 1'b0, 0, 2'd3, 1'b0, "R1");
            lat = 1;
            while (ser_out !== 1'b1 && lat < NS + 5) begin
                step(1'b0, 1'b0, 0, 2'd3, 1'b0, "R1");
                lat++;
            end
            n_chk++;
            if (lat != NS) begin
                n_bad++;
                $display("FAIL R1 latency: actual %0d expected %0d", lat, NS);
            end
        end

        // R8: reset mid-stream clears everything
        step(1'b1, 1'b1, 5, 2'd2, 1'b0, "R8");
        rst_n = 1'b0;
        step(1'b1, 1'b1, 5, 2'd0, 1'b0, "R8");
        check("R8", "mism_hold reset", mism_hold, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 2'd3, 1'b0, "R8");

        summary();
        $finish;
    end

endmodule